// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupt Detection

A memory-mapped general-purpose I/O controller whose pins are grouped into 32-pin banks. Every control and status group has one 32-bit word per bank, placed at a 4-byte stride from the group's base. Software uses the groups to set pin direction, to drive output latches through separate write-only set and clear words, and to read back the conditioned input level.

Each pin has its own interrupt detector. A detector is either edge-triggered, with independent rising and falling enables, or level-triggered, with a polarity choice. Detections land in a sticky, write-one-to-clear source word. A per-pin mask gates the source bits into one registered interrupt line shared by all banks.

Every input passes through a two-flop synchroniser. Unless a pin's bypass bit is set, a stability filter then removes pulses that are shorter than two cycles.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Pin n uses bit (n mod 32) of the word at group base + (n/32)*4. The group bases are: level 0x004, direction 0x01C, set 0x034, clear 0x04C, rising enable 0x064, falling enable 0x07C, filter bypass 0x094, mask 0x0AC, source 0x0C4, detect type 0x300, polarity 0x318. bus_rdata holds the word addressed on the previous cycle.
- R2: A direction bit of 1 makes the pin an output (pins_oe high). A direction bit of 0 makes it an input. Direction words read back as written.
- R3: Writing 1 to a bit of a set word drives that pin's output latch high. Writing 1 to a bit of a clear word drives it low. Zero bits leave the latch unchanged. Set and clear words read as 0.
- R4: The level word returns the conditioned state of the bank's input pins. Writes to the level word change nothing.
- R5: With detect type 0 (edge), a rising edge sets the source bit when the rising enable is 1, and a falling edge sets it when the falling enable is 1. With both enables set, either edge sets it.
- R6: With detect type 1 (level), the source bit is set on every cycle the pin is active. Active is high when polarity is 0 and low when polarity is 1. A clear therefore does not hold while the pin stays active.
- R7: Writing 1 to a source bit clears it, and writing 0 has no effect. In edge mode a source bit stays set until it is cleared.
- R8: irq_out is the registered OR, over all banks, of (source AND mask), where a mask bit of 1 enables the pin.
- R9: With bypass 0, a synchronised level must hold for two cycles before detection and the level word see it, so a one-cycle pulse is dropped. With bypass 1, the synchronised value is used directly.
- R10: After reset every direction, enable, mask, type, polarity, bypass and source bit is 0, the output latches are low and irq_out is 0. Reads of 0x000 and of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 10 | Byte address of the register word |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pins_in | input | NBANKS*32 | Pin input levels (asynchronous) |
| pins_out | output | NBANKS*32 | Output latch values |
| pins_oe | output | NBANKS*32 | Output enables (direction bits) |
| irq_out | output | 1 | Aggregated registered interrupt |

## Verification
The effects of a write (direction, latches, mask) appear at the ports one cycle after the write edge. irq_out follows a source or mask change one cycle later. Read data is due one cycle after the address is presented. With bypass, a pin change reaches a source bit three edges after it is applied, and irq_out one edge after that. With the filter in use, each of these takes two edges more. After every pin change the bench waits eight cycles, which is beyond the longest of these paths, before it samples. Each read is queued together with its expected word, and that word is compared in the cycle the registered read data becomes valid.

// File: rtl/gbc_pkg.sv
package gbc_pkg;
  localparam int BANK_W = 32;
  localparam int AW     = 10;

  localparam logic [AW-1:0] OFS_LVL  = 10'h004;
  localparam logic [AW-1:0] OFS_DIR  = 10'h01C;
  localparam logic [AW-1:0] OFS_SET  = 10'h034;
  localparam logic [AW-1:0] OFS_CLR  = 10'h04C;
  localparam logic [AW-1:0] OFS_RISE = 10'h064;
  localparam logic [AW-1:0] OFS_FALL = 10'h07C;
  localparam logic [AW-1:0] OFS_BYP  = 10'h094;
  localparam logic [AW-1:0] OFS_MASK = 10'h0AC;
  localparam logic [AW-1:0] OFS_SRC  = 10'h0C4;
  localparam logic [AW-1:0] OFS_TYPE = 10'h300;
  localparam logic [AW-1:0] OFS_POL  = 10'h318;

  typedef enum logic [3:0] {
    G_NONE, G_LVL, G_DIR, G_SET, G_CLR, G_RISE,
    G_FALL, G_BYP, G_MASK, G_SRC, G_TYPE, G_POL
  } grp_e;

  typedef struct packed {
    grp_e       grp;
    logic [2:0] bank;
  } dec_t;

  // Map a byte address to register group and bank; at most 6 banks fit the gaps.
  function automatic dec_t decode(input logic [AW-1:0] a, input int nb);
    dec_t d;
    d.grp  = G_NONE;
    d.bank = '0;
    for (int b = 0; b < 6; b++) begin
      if (b < nb) begin
        logic [AW-1:0] o;
        o = AW'(b * 4);
        if      (a == OFS_LVL  + o) begin d.grp = G_LVL;  d.bank = 3'(b); end
        else if (a == OFS_DIR  + o) begin d.grp = G_DIR;  d.bank = 3'(b); end
        else if (a == OFS_SET  + o) begin d.grp = G_SET;  d.bank = 3'(b); end
        else if (a == OFS_CLR  + o) begin d.grp = G_CLR;  d.bank = 3'(b); end
        else if (a == OFS_RISE + o) begin d.grp = G_RISE; d.bank = 3'(b); end
        else if (a == OFS_FALL + o) begin d.grp = G_FALL; d.bank = 3'(b); end
        else if (a == OFS_BYP  + o) begin d.grp = G_BYP;  d.bank = 3'(b); end
        else if (a == OFS_MASK + o) begin d.grp = G_MASK; d.bank = 3'(b); end
        else if (a == OFS_SRC  + o) begin d.grp = G_SRC;  d.bank = 3'(b); end
        else if (a == OFS_TYPE + o) begin d.grp = G_TYPE; d.bank = 3'(b); end
        else if (a == OFS_POL  + o) begin d.grp = G_POL;  d.bank = 3'(b); end
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/gbc_sync_filter.sv
module gbc_sync_filter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic [W-1:0] byp,
  output logic [W-1:0] dout
);
  logic [W-1:0] s1, s2, hist, filt;
  logic [W-1:0] steady;

  assign steady = ~(s2 ^ hist);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= '0;
      s2   <= '0;
      hist <= '0;
      filt <= '0;
    end else begin
      s1   <= din;
      s2   <= s1;
      hist <= s2;
      filt <= (steady & s2) | (~steady & filt);
    end
  end

  assign dout = (byp & s2) | (~byp & filt);
endmodule

// File: rtl/gbc_bank.sv
module gbc_bank
  import gbc_pkg::*;
#(
  parameter int W = BANK_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin,
  input  grp_e         wgrp,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dir,
  output logic [W-1:0] outq,
  output logic [W-1:0] ren,
  output logic [W-1:0] fen,
  output logic [W-1:0] byp,
  output logic [W-1:0] mask,
  output logic [W-1:0] typ,
  output logic [W-1:0] pol,
  output logic [W-1:0] src
);
  logic [W-1:0] prev, evt, clr;

  assign evt = (typ & (pin ^ pol))
             | (~typ & ((ren & pin & ~prev) | (fen & ~pin & prev)));
  assign clr = (wgrp == G_SRC) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= '0; dir <= '0; outq <= '0; ren <= '0; fen <= '0;
      byp  <= '0; mask <= '0; typ <= '0; pol <= '0; src <= '0;
    end else begin
      prev <= pin;
      src  <= (src & ~clr) | evt;
      case (wgrp)
        G_DIR:  dir  <= wdata;
        G_SET:  outq <= outq | wdata;
        G_CLR:  outq <= outq & ~wdata;
        G_RISE: ren  <= wdata;
        G_FALL: fen  <= wdata;
        G_BYP:  byp  <= wdata;
        G_MASK: mask <= wdata;
        G_TYPE: typ  <= wdata;
        G_POL:  pol  <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gbc_pkg::*;
#(
  parameter int NBANKS = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [AW-1:0]            bus_addr,
  input  logic                     bus_we,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic [NBANKS*BANK_W-1:0] pins_in,
  output logic [NBANKS*BANK_W-1:0] pins_out,
  output logic [NBANKS*BANK_W-1:0] pins_oe,
  output logic                     irq_out
);
  localparam int BW = (NBANKS > 1) ? $clog2(NBANKS) : 1;

  typedef logic [NBANKS-1:0][BANK_W-1:0] bankv_t;
  bankv_t clean_a, dir_a, out_a, ren_a, fen_a, byp_a, mask_a, typ_a, pol_a, src_a;

  dec_t          dec;
  logic [BW-1:0] bsel;
  logic [31:0]   rd_nxt;
  logic          pend_any;

  assign dec  = decode(bus_addr, NBANKS);
  assign bsel = BW'(dec.bank);

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    grp_e wg;
    assign wg = (bus_we && dec.bank == 3'(b)) ? dec.grp : G_NONE;

    gbc_sync_filter #(.W(BANK_W)) u_sf (
      .clk (clk), .rst (rst),
      .din (pins_in[b*BANK_W +: BANK_W]),
      .byp (byp_a[b]),
      .dout(clean_a[b])
    );

    gbc_bank #(.W(BANK_W)) u_bank (
      .clk (clk), .rst (rst), .pin (clean_a[b]), .wgrp(wg), .wdata(bus_wdata),
      .dir (dir_a[b]), .outq(out_a[b]), .ren(ren_a[b]), .fen(fen_a[b]),
      .byp (byp_a[b]), .mask(mask_a[b]), .typ(typ_a[b]), .pol(pol_a[b]),
      .src (src_a[b])
    );
  end

  always_comb begin
    case (dec.grp)
      G_LVL:   rd_nxt = clean_a[bsel];
      G_DIR:   rd_nxt = dir_a[bsel];
      G_RISE:  rd_nxt = ren_a[bsel];
      G_FALL:  rd_nxt = fen_a[bsel];
      G_BYP:   rd_nxt = byp_a[bsel];
      G_MASK:  rd_nxt = mask_a[bsel];
      G_SRC:   rd_nxt = src_a[bsel];
      G_TYPE:  rd_nxt = typ_a[bsel];
      G_POL:   rd_nxt = pol_a[bsel];
      default: rd_nxt = '0;
    endcase
  end

  assign pend_any = |(src_a & mask_a);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      bus_rdata <= rd_nxt;
      irq_out   <= pend_any;
    end
  end

  assign pins_out = out_a;
  assign pins_oe  = dir_a;
endmodule

// File: rtl/gbc_checker.sv
module gbc_checker
  import gbc_pkg::*;
#(
  parameter int NBANKS = 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic [AW-1:0]            bus_addr,
  input logic                     bus_we,
  input logic [31:0]              bus_wdata,
  input logic [31:0]              bus_rdata,
  input logic [NBANKS*BANK_W-1:0] pins_out,
  input logic [NBANKS*BANK_W-1:0] pins_oe,
  input logic                     irq_out
);
  a_r10_reset_clean: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pins_oe == '0 && pins_out == '0 && !irq_out));

  a_r3_set_drives_high: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFS_SET) |=>
      ((pins_out[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

  a_r3_clear_drives_low: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFS_CLR) |=>
      ((pins_out[31:0] & $past(bus_wdata)) == '0));

  a_r2_dir_to_oe: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFS_DIR) |=> (pins_oe[31:0] == $past(bus_wdata)));

  a_r3_write_only_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == OFS_SET || bus_addr == OFS_CLR) |=> (bus_rdata == '0));
endmodule

bind gpio_bank_ctrl gbc_checker #(.NBANKS(NBANKS)) u_gbc_checker (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pins_out(pins_out),
  .pins_oe(pins_oe), .irq_out(irq_out)
);

// File: tb/test_gpio_bank_ctrl.sv
module test_gpio_bank_ctrl;
  logic        clk = 0;
  logic        rst = 1;
  logic [9:0]  bus_addr = '0;
  logic        bus_we = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] pins_in = '0;
  logic [63:0] pins_out, pins_oe;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  logic rd_req = 0;
  logic rd_pend = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  gpio_bank_ctrl #(.NBANKS(2)) i_gpio_bank_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pins_in(pins_in),
    .pins_out(pins_out), .pins_oe(pins_oe), .irq_out(irq_out)
  );

  always @(posedge clk) rd_pend <= rd_req;

  // Monitor: compares read data in the cycle it becomes valid
  always @(negedge clk) begin
    item_t it;
    if (rd_pend) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty, actual %h expected none", bus_rdata);
      end else begin
        it = q.pop_front();
        if (bus_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    it.exp = e; it.tag = tag;
    q.push_back(it);
    bus_addr = a; rd_req = 1;
    @(negedge clk);
    rd_req = 0;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk("R10 pins_oe", pins_oe, 64'h0);
    chk("R10 pins_out", pins_out, 64'h0);
    chk("R10 irq_out", {63'h0, irq_out}, 64'h0);
    rd(10'h000, 32'h0, "R10 config word");
    rd(10'h0C4, 32'h0, "R10 source");
    rd(10'h300, 32'h0, "R10 type");
    rd(10'h3F0, 32'h0, "R10 unmapped");

    // R2 direction, bank 1
    wr(10'h020, 32'hA5A5_0000);
    chk("R2 pins_oe bank1", pins_oe, 64'hA5A5_0000_0000_0000);
    rd(10'h020, 32'hA5A5_0000, "R2 dir readback");

    // R3 set/clear
    wr(10'h034, 32'h0000_00FF);
    chk("R3 set", pins_out, 64'h0000_00FF);
    wr(10'h034, 32'h0000_0100);
    chk("R3 set keeps", pins_out, 64'h0000_01FF);
    wr(10'h04C, 32'h0000_000F);
    chk("R3 clear", pins_out, 64'h0000_01F0);
    rd(10'h034, 32'h0, "R3 set reads 0");
    rd(10'h04C, 32'h0, "R3 clear reads 0");
    // R1 pin 35 lives in bank 1 bit 3
    wr(10'h038, 32'h0000_0008);
    chk("R1 pin35 set", pins_out, 64'h0000_0008_0000_01F0);

    // R4 level word
    wr(10'h094, 32'hFFFF_FFFF);
    wr(10'h098, 32'hFFFF_FFFF);
    pins_in = 64'h1234_5678_9ABC_DEF0;
    settle();
    rd(10'h004, 32'h9ABC_DEF0, "R4 level bank0");
    rd(10'h008, 32'h1234_5678, "R4 level bank1");
    wr(10'h004, 32'h0);
    rd(10'h004, 32'h9ABC_DEF0, "R4 level write ignored");

    pins_in = '0;
    settle();
    wr(10'h0C4, 32'hFFFF_FFFF);
    wr(10'h0C8, 32'hFFFF_FFFF);

    // R5/R7 edge detection, bank 0
    wr(10'h0AC, 32'hFFFF_FFFF);
    wr(10'h064, 32'h1);
    wr(10'h07C, 32'h2);
    pins_in[0] = 1; settle();
    rd(10'h0C4, 32'h1, "R5 rising sets");
    chk("R8 irq on", {63'h0, irq_out}, 64'h1);
    pins_in[0] = 0; settle();
    rd(10'h0C4, 32'h1, "R7 edge source sticky");
    wr(10'h0C4, 32'h0);
    rd(10'h0C4, 32'h1, "R7 write 0 no effect");
    wr(10'h0C4, 32'h1);
    rd(10'h0C4, 32'h0, "R7 write 1 clears");
    repeat (2) @(negedge clk);
    chk("R8 irq off", {63'h0, irq_out}, 64'h0);
    pins_in[1] = 1; settle();
    rd(10'h0C4, 32'h0, "R5 rise ignored with only fall enable");
    pins_in[1] = 0; settle();
    rd(10'h0C4, 32'h2, "R5 falling sets");
    wr(10'h0C4, 32'h2);
    wr(10'h064, 32'h5);
    wr(10'h07C, 32'h6);
    pins_in[2] = 1; settle();
    rd(10'h0C4, 32'h4, "R5 both enables rise");
    wr(10'h0C4, 32'h4);
    pins_in[2] = 0; settle();
    rd(10'h0C4, 32'h4, "R5 both enables fall");
    wr(10'h0C4, 32'h4);

    // R8 masking
    wr(10'h0AC, 32'hFFFF_FFFE);
    pins_in[0] = 1; settle();
    rd(10'h0C4, 32'h1, "R8 masked source still latched");
    chk("R8 masked no irq", {63'h0, irq_out}, 64'h0);
    wr(10'h0AC, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    chk("R8 unmask raises irq", {63'h0, irq_out}, 64'h1);
    pins_in[0] = 0; settle();
    wr(10'h0C4, 32'h1);
    repeat (2) @(negedge clk);
    chk("R8 irq drops", {63'h0, irq_out}, 64'h0);

    // R6 level mode, pin 40 = bank1 bit 8
    wr(10'h0B0, 32'h100);
    wr(10'h304, 32'h100);
    settle();
    rd(10'h0C8, 32'h0, "R6 inactive low");
    pins_in[40] = 1; settle();
    rd(10'h0C8, 32'h100, "R6 active high sets");
    chk("R6 irq bank1", {63'h0, irq_out}, 64'h1);
    wr(10'h0C8, 32'h100);
    rd(10'h0C8, 32'h100, "R6 reasserts while active");
    pins_in[40] = 0; settle();
    wr(10'h0C8, 32'h100);
    rd(10'h0C8, 32'h0, "R6 clears when inactive");
    wr(10'h31C, 32'h100);
    settle();
    rd(10'h0C8, 32'h100, "R6 polarity low active");
    pins_in[40] = 1; settle();
    wr(10'h0C8, 32'h100);
    rd(10'h0C8, 32'h0, "R6 polarity high inactive");
    repeat (2) @(negedge clk);
    chk("R6 irq off", {63'h0, irq_out}, 64'h0);

    // R9 glitch filter on pin 3
    wr(10'h094, 32'hFFFF_FFF7);
    wr(10'h064, 32'h0000_000D);
    @(negedge clk); pins_in[3] = 1;
    @(negedge clk); pins_in[3] = 0;
    settle();
    rd(10'h0C4, 32'h0, "R9 filter drops 1-cycle pulse");
    pins_in[3] = 1; settle();
    rd(10'h0C4, 32'h8, "R9 filter passes stable level");
    rd(10'h004, 32'h8, "R9 filtered level");
    wr(10'h0C4, 32'h8);
    pins_in[3] = 0; settle();
    wr(10'h094, 32'hFFFF_FFFF);
    @(negedge clk); pins_in[3] = 1;
    @(negedge clk); pins_in[3] = 0;
    settle();
    rd(10'h0C4, 32'h8, "R9 bypass passes pulse");

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule